// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz tick into a programmable periodic interrupt. A free-running tick counter advances on every tick. When periodic interrupts are enabled and the 4-bit rate code is nonzero, an event fires each time the counter reaches a multiple of the selected period. The events therefore fall on boundaries fixed by the counter. They are not timed from the moment software programs the rate.

Each event sets two bits in an 8-bit interrupt flag byte and raises the interrupt request. A read strobe on the flag byte returns its current contents and clears it. Alarm, update-ended, calendar, lost-interrupt pacing and bus decode belong to neighbouring blocks.

Top module: `pirq_rate_gen`

## Requirements
- R1: While reset is asserted, and on leaving reset, `flag_q` is 0x00 and `irq_o` is low.
- R2: For rate codes 3 to 15, an event fires on the tick edge where the incremented free-running count (15 bits, reset to 0, wrapping) is a multiple of 2^(code-1). The count advances on every tick, whether interrupts are enabled or not.
- R3: Rate code 1 behaves as code 8 (period 128 ticks), and rate code 2 behaves as code 9 (period 256 ticks).
- R4: With rate code 0, or with `pie_en` low, no event fires and the flag byte stays unchanged.
- R5: When interrupts are enabled part way through a period, the first event comes at the next aligned boundary of the free-running count, not a full period after enabling.
- R6: An event sets bit 7 (interrupt pending) and bit 6 (periodic source) of `flag_q` on the clock edge that takes the tick. Bits 5 to 0 always read 0, and `irq_o` always equals bit 7.
- R7: `flag_q` shows the current flag byte during a read cycle. After the edge that ends a read cycle, the byte is 0x00 and `irq_o` is low, unless R8 applies. Without a read, the set bits stay set.
- R8: If a read and an event fall on the same edge, the flag byte after that edge is 0xC0.
- R9: A rate code change part way through a period produces no extra event. The next event falls on the next boundary aligned to the new period.
- R10: The count and events advance only on edges where `tick_32k` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_sel | input | 4 | Periodic rate code, 0 disables |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_rd | input | 1 | Read strobe for the flag byte, clears it |
| flag_q | output | 8 | Interrupt flag byte (bit 7 pending, bit 6 periodic) |
| irq_o | output | 1 | Interrupt request, high while bit 7 is set |

## Verification
A behavioural model of the tick count and the flag byte is compared with the outputs on every clock. The stimulus covers the following patterns:
- Ticks on every cycle and on every third cycle, which separates counting on ticks from counting on clocks.
- The short rate codes against the two aliased codes, which exposes a wrong period mapping.
- Enabling, and changing the rate code, at unaligned counts, which separates boundary alignment from counting out of a reload.
- Reads placed exactly on an event edge, which show whether the new flags survive the clear.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned RATE_W  = 4;
   localparam int unsigned SHIFT_W = 4;
   localparam int unsigned FLAG_W  = 8;
   localparam int unsigned IRQ_BIT = 7;
   localparam int unsigned PER_BIT = 6;

   typedef logic [SHIFT_W-1:0] shift_t;

   // log2 of the period in ticks; codes 1 and 2 alias to 8 and 9
   function automatic shift_t rate_to_shift(input logic [RATE_W-1:0] code);
      logic [RATE_W:0] eff;
      eff = {1'b0, code};
      if (code == 4'd1 || code == 4'd2)
         eff = eff + 5'd7;
      return shift_t'(eff - 5'd1);
   endfunction
endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
   import pirq_pkg::*;
(
   input  logic [RATE_W-1:0] rate_code,
   input  logic              enable,
   output logic              active,
   output shift_t            shift
);
   assign active = enable && (rate_code != '0);
   assign shift  = rate_to_shift(rate_code);
endmodule

// File: rtl/pirq_tick_cnt.sv
module pirq_tick_cnt #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_nxt
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/pirq_edge_detect.sv
module pirq_edge_detect
   import pirq_pkg::*;
#(
   parameter int unsigned CNT_W = 15
) (
   input  logic             tick,
   input  logic             active,
   input  shift_t           shift,
   input  logic [CNT_W-1:0] cnt_nxt,
   output logic             hit
);
   logic [CNT_W-1:0] mask;

   // thermometer mask of the low 'shift' bits
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign mask[i] = (32'(shift) > i);
   end

   assign hit = tick && active && ((cnt_nxt & mask) == '0);
endmodule

// File: rtl/pirq_flag_reg.sv
module pirq_flag_reg
   import pirq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_evt,
   input  logic              rd,
   output logic [FLAG_W-1:0] flags,
   output logic              irq
);
   logic [FLAG_W-1:0] set_mask;
   logic [FLAG_W-1:0] flags_d;

   always_comb begin
      set_mask          = '0;
      set_mask[IRQ_BIT] = set_evt;
      set_mask[PER_BIT] = set_evt;
      flags_d           = (rd ? '0 : flags) | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= flags_d;
   end

   assign irq = flags[IRQ_BIT];
endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen
   import pirq_pkg::*;
#(
   parameter int unsigned CNT_W = 15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_32k,
   input  logic [3:0]  rate_sel,
   input  logic        pie_en,
   input  logic        flag_rd,
   output logic [7:0]  flag_q,
   output logic        irq_o
);
   localparam int unsigned MAX_SHIFT = (1 << SHIFT_W) - 2;

   if (CNT_W < MAX_SHIFT + 1) begin : g_bad_width
      $error("CNT_W must cover the longest period");
   end

   logic             active;
   shift_t           shift;
   logic [CNT_W-1:0] cnt_nxt;
   logic             hit;

   pirq_rate_decode u_dec (
      .rate_code (rate_sel),
      .enable    (pie_en),
      .active    (active),
      .shift     (shift)
   );

   pirq_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_32k),
      .cnt_nxt (cnt_nxt)
   );

   pirq_edge_detect #(.CNT_W(CNT_W)) u_det (
      .tick    (tick_32k),
      .active  (active),
      .shift   (shift),
      .cnt_nxt (cnt_nxt),
      .hit     (hit)
   );

   pirq_flag_reg u_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (hit),
      .rd      (flag_rd),
      .flags   (flag_q),
      .irq     (irq_o)
   );
endmodule

// File: rtl/pirq_rate_gen_chk.sv
module pirq_rate_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_32k,
   input logic [3:0] rate_sel,
   input logic       pie_en,
   input logic       flag_rd,
   input logic [7:0] flag_q,
   input logic       irq_o
);
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (flag_q == 8'h00 && !irq_o));

   p_spare_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[5:0] == 6'd0);

   p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == flag_q[7]);

   // events need enable, nonzero code and a tick (R4, R10)
   p_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[6]) |-> ($past(pie_en) && $past(rate_sel) != 4'd0 && $past(tick_32k)));

   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_rd |=> (flag_q == 8'h00 || flag_q == 8'hC0));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_rd && flag_q[7]) |=> flag_q[7]);
endmodule

bind pirq_rate_gen pirq_rate_gen_chk u_chk (.*);

// File: tb/pirq_rate_gen_tb.sv
module pirq_rate_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       pie = 1'b0;
   logic       rd = 1'b0;
   logic [3:0] rate = 4'd0;
   logic [7:0] flag_q;
   logic       irq;

   int    checks = 0;
   int    errors = 0;
   int    m_cnt = 0;
   int    m_flags = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   pirq_rate_gen dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_32k (tick),
      .rate_sel (rate),
      .pie_en   (pie),
      .flag_rd  (rd),
      .flag_q   (flag_q),
      .irq_o    (irq)
   );

   function automatic int period_of(int code);
      int e;
      e = (code == 1 || code == 2) ? code + 7 : code;
      return 1 << (e - 1);
   endfunction

   function automatic bit will_hit(bit t, int code, bit en);
      if (!t || !en || code == 0) return 1'b0;
      return (((m_cnt + 1) % 32768) % period_of(code)) == 0;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(bit t, int code, bit en, bit r);
      bit h;
      h = will_hit(t, code, en);
      tick = t; rate = 4'(code); pie = en; rd = r;
      if (t) m_cnt = (m_cnt + 1) % 32768;
      m_flags = (r ? 0 : m_flags) | (h ? 8'hC0 : 0);
      @(posedge clk);
      @(negedge clk);
      check(cur_req, int'(flag_q), m_flags);
      check(cur_req, int'(irq), (m_flags >> 7) & 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(flag_q), 0);
      check("R1", int'(irq), 0);
      rst_n = 1'b1;
      cur_req = "R1";
      repeat (5) step(1'b0, 0, 1'b0, 1'b0);

      cur_req = "R2";
      for (int i = 0; i < 64; i++) step(1'b1, 3, 1'b1, (i % 8) == 7);

      cur_req = "R6";
      while (!will_hit(1'b1, 4, 1'b1)) step(1'b1, 4, 1'b1, 1'b0);
      step(1'b1, 4, 1'b1, 1'b0);
      check("R6", int'(flag_q), 8'hC0);
      check("R6", int'(irq), 1);

      cur_req = "R7";
      step(1'b0, 4, 1'b1, 1'b1);
      check("R7", int'(flag_q), 0);
      check("R7", int'(irq), 0);

      cur_req = "R10";
      for (int i = 0; i < 120; i++) step((i % 3) == 0, 6, 1'b1, (i % 40) == 39);

      cur_req = "R3";
      for (int c = 1; c <= 2; c++)
         for (int i = 0; i < 600; i++) step(1'b1, c, 1'b1, (i % 100) == 99);

      cur_req = "R4";
      step(1'b0, 0, 1'b1, 1'b1);
      for (int i = 0; i < 100; i++) step(1'b1, 0, 1'b1, 1'b0);
      for (int i = 0; i < 100; i++) step(1'b1, 5, 1'b0, 1'b0);
      check("R4", int'(flag_q), 0);

      cur_req = "R5";
      for (int i = 0; i < 37; i++) step(1'b1, 5, 1'b0, 1'b0);
      for (int i = 0; i < 100; i++) step(1'b1, 5, 1'b1, (i % 20) == 19);

      cur_req = "R8";
      while (!will_hit(1'b1, 3, 1'b1)) step(1'b1, 3, 1'b1, 1'b0);
      step(1'b1, 3, 1'b1, 1'b1);
      check("R8", int'(flag_q), 8'hC0);

      cur_req = "R9";
      for (int i = 0; i < 300; i++) step(1'b1, 10, 1'b1, (i % 50) == 49);
      for (int i = 0; i < 300; i++) step(1'b1, 7, 1'b1, (i % 50) == 49);
      for (int i = 0; i < 200; i++) step(1'b1, 9, 1'b1, (i % 50) == 49);

      cur_req = "R2";
      for (int i = 0; i < 17000; i++) step(1'b1, 15, 1'b1, (i % 5000) == 4999);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule